// File: doc/BRIEF.md
# Processor trap entry sequencer

This block carries out the entry step of a trap for a small 32-bit soft processor. Four kinds of event can start a trap: an external interrupt, a hardware exception, a memory translation fault and a hardware break. In the clock edge where a trap is accepted, the block does all of its work at once. It picks the handler vector as an offset from a configurable base address. It writes the return address into the link register that belongs to the event kind. It moves the virtual-mode and user-mode status bits one position up into their saved copies and clears the live bits. For exceptions it also fills in the syndrome, the fault address and the captured branch target.

The processor core supplies the current PC, its delay-slot and immediate-prefix flags, the pending branch target and the details of any translation fault. The block returns a register-file write, a PC load and a pulse that clears the instruction flags. The machine status register, the syndrome register, the fault-address register and the branch-target register live inside the block and are visible as outputs. The core's move-to-status instruction writes the machine status register through a load port. That port is also how a handler re-enables interrupts or ends an exception.

Top module: `trap_entry_ctrl`

## Requirements
- R1: An interrupt is taken only when all of the following hold: status bit 1 (interrupt enable) is 1, status bit 9 (exception in progress) is 0, status bit 3 (break in progress) is 0, `in_dslot_i` is 0 and `after_imm_i` is 0. Otherwise the interrupt causes no write and no PC load.
- R2: Interrupt entry does three things. It writes the PC to register 14. It loads the PC with base + 0x10. It clears status bit 1.
- R3: Break entry does three things. It writes the PC to register 16. It sets status bit 3. It loads the PC with base + 0x18.
- R4: Hardware exception entry does three things. It writes PC+4 to register 17. It sets status bit 9. It loads base + 0x20. All other syndrome bits are kept.
- R5: Every trap entry applies the same status change, whatever the event.
  - Bit 13 (VM) is copied into bit 14.
  - Bit 11 (UM) is copied into bit 12.
  - Bits 13 and 11 are then cleared.
  - All other status bits are kept, except those the event kind itself changes.
- R6: On hardware exception and translation fault entry, syndrome bit 12 is cleared. If the trapped instruction sat in a delay slot, bit 12 is set to 1 and the branch-target register captures `btarget_i`. Otherwise the branch-target register is unchanged.
- R7: A translation fault sets the syndrome as follows:
  - The whole syndrome is replaced by a code plus two flags.
  - The code is 16 + 2·`tf_class_i` + fetch. The access kind `tf_kind_i` is 00 for a load, 01 for a store and 10 for a fetch, so fetch is 1 only for kind 10.
  - Bit 10 is 1 for a store.
  - Bit 12 is the delay-slot flag.
  - The fault address goes to the fault-address register.
  - Status bit 9 is set and the PC loads base + 0x20.
- R8: A translation fault writes a re-execute address to register 17:
  - PC minus 4 in a delay slot after a branch without an immediate prefix;
  - PC minus 8 in a delay slot after a branch with an immediate prefix (`branch_imm_i`);
  - PC minus 4 right after an immediate-prefix instruction;
  - otherwise the PC itself.
- R9: With parameter `EXC_EN` = 0, a hardware exception request is ignored: there is no write, no PC load and no status change.
- R10: A translation fault entry marks a fault as in service. The mark clears when the status register is loaded with bit 9 = 0. A translation fault request while the mark is set is not taken and sets `recursive_err_o`, which stays set until reset.
- R11: Simultaneous events are served in this order: break, then translation fault, then hardware exception, then interrupt. All updates appear together one clock after the request, with `flag_clr_o` pulsed.
- R12: After reset all registers and outputs are zero. When no trap is taken, `msr_we_i` loads `msr_wdata_i` into the status register. A trap in the same cycle takes precedence over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | PC of the current instruction |
| in_dslot_i | input | 1 | Current instruction is in a branch delay slot |
| after_imm_i | input | 1 | Current instruction follows an immediate prefix |
| branch_imm_i | input | 1 | The branch owning the delay slot had an immediate prefix |
| btarget_i | input | XLEN | Pending branch target |
| irq_i | input | 1 | External interrupt request |
| brk_req_i | input | 1 | Hardware break request |
| hwexc_req_i | input | 1 | Hardware exception request |
| tfault_req_i | input | 1 | Translation fault request |
| tf_class_i | input | 1 | Fault class (0 selects codes 16/17, 1 selects 18/19) |
| tf_kind_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| tf_addr_i | input | XLEN | Faulting address |
| msr_we_i | input | 1 | Load the status register |
| msr_wdata_i | input | XLEN | Status register load value |
| rf_we_o | output | 1 | Link register write enable |
| rf_waddr_o | output | RF_AW | Link register index |
| rf_wdata_o | output | XLEN | Return address |
| pc_load_o | output | 1 | Load the PC with pc_next_o |
| pc_next_o | output | XLEN | Handler vector |
| flag_clr_o | output | 1 | Clear delay-slot and immediate-prefix flags |
| msr_o | output | XLEN | Machine status register |
| esr_o | output | XLEN | Exception syndrome register |
| ear_o | output | XLEN | Fault address register |
| btr_o | output | XLEN | Captured branch target register |
| recursive_err_o | output | 1 | Sticky recursive translation fault error |

## Verification
Four checks run on every cycle:
- no interrupt is taken inside a delay slot or after a prefix;
- each entry leaves the mode bits moved up and cleared;
- each vector matches its link register;
- an interrupt cannot enter twice in a row, and the recursive error stays set.

The other behaviours can only be shown by the bench's scenarios, which compare every output against a reference model:
- the syndrome codes and the store flag;
- the four re-execute address variants;
- the priority among simultaneous events;
- the recursive-fault sequence;
- the ignored exception in the variant without exception support.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   typedef enum logic [2:0] {
      TK_NONE   = 3'd0,
      TK_IRQ    = 3'd1,
      TK_BRK    = 3'd2,
      TK_HWEXC  = 3'd3,
      TK_TFAULT = 3'd4
   } trap_kind_e;

   // status register bit positions; saved copies sit one bit above the live bits
   localparam int ST_IE  = 1;
   localparam int ST_BIP = 3;
   localparam int ST_EIP = 9;
   localparam int ST_UM  = 11;
   localparam int ST_UMS = ST_UM + 1;
   localparam int ST_VM  = 13;
   localparam int ST_VMS = ST_VM + 1;
   localparam int ST_TOP = ST_VMS;

   // syndrome bit positions
   localparam int SY_STORE = 10;
   localparam int SY_DSLOT = 12;
   localparam int SY_CODE_W = 5;
   localparam int SY_TF_BASE = 16;

   // handler vector offsets
   localparam int VOFS_IRQ = 'h10;
   localparam int VOFS_BRK = 'h18;
   localparam int VOFS_EXC = 'h20;

   localparam logic [1:0] TF_LOAD  = 2'b00;
   localparam logic [1:0] TF_STORE = 2'b01;
   localparam logic [1:0] TF_FETCH = 2'b10;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_entry_pkg::*;
#(
   parameter bit EXC_EN = 1'b1
) (
   input  logic       irq_i,
   input  logic       brk_i,
   input  logic       hwexc_i,
   input  logic       tfault_i,
   input  logic       ie_i,
   input  logic       eip_i,
   input  logic       bip_i,
   input  logic       in_dslot_i,
   input  logic       after_imm_i,
   input  logic       tf_busy_i,
   output trap_kind_e kind_o,
   output logic       recur_o
);

   logic hx_eff;
   logic irq_ok;
   logic tf_ok;

   generate
      if (EXC_EN) begin : g_exc
         assign hx_eff = hwexc_i;
      end else begin : g_noexc
         logic unused_hx;
         assign unused_hx = hwexc_i;
         assign hx_eff    = 1'b0;
      end
   endgenerate

   assign irq_ok  = irq_i & ie_i & ~eip_i & ~bip_i & ~in_dslot_i & ~after_imm_i;
   assign tf_ok   = tfault_i & ~tf_busy_i;
   assign recur_o = tfault_i & tf_busy_i;

   always_comb begin
      if (brk_i)       kind_o = TK_BRK;
      else if (tf_ok)  kind_o = TK_TFAULT;
      else if (hx_eff) kind_o = TK_HWEXC;
      else if (irq_ok) kind_o = TK_IRQ;
      else             kind_o = TK_NONE;
   end

endmodule

// File: rtl/trap_msr_upd.sv
module trap_msr_upd
   import trap_entry_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] msr_cur_i,
   input  trap_kind_e      kind_i,
   input  logic            msr_we_i,
   input  logic [XLEN-1:0] msr_wdata_i,
   output logic [XLEN-1:0] msr_nxt_o
);

   logic [XLEN-1:0] saved;

   always_comb begin
      saved         = msr_cur_i;
      saved[ST_VMS] = msr_cur_i[ST_VM];
      saved[ST_UMS] = msr_cur_i[ST_UM];
      saved[ST_VM]  = 1'b0;
      saved[ST_UM]  = 1'b0;
   end

   always_comb begin
      msr_nxt_o = msr_cur_i;
      unique case (kind_i)
         TK_IRQ: begin
            msr_nxt_o        = saved;
            msr_nxt_o[ST_IE] = 1'b0;
         end
         TK_BRK: begin
            msr_nxt_o         = saved;
            msr_nxt_o[ST_BIP] = 1'b1;
         end
         TK_HWEXC, TK_TFAULT: begin
            msr_nxt_o         = saved;
            msr_nxt_o[ST_EIP] = 1'b1;
         end
         default: begin
            if (msr_we_i) msr_nxt_o = msr_wdata_i;
         end
      endcase
   end

endmodule

// File: rtl/trap_syndrome.sv
module trap_syndrome
   import trap_entry_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              RF_AW    = 5,
   parameter logic [XLEN-1:0] BASE_VEC = '0,
   parameter int              LR_IRQ   = 14,
   parameter int              LR_BRK   = 16,
   parameter int              LR_EXC   = 17
) (
   input  trap_kind_e       kind_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic             in_dslot_i,
   input  logic             after_imm_i,
   input  logic             branch_imm_i,
   input  logic [XLEN-1:0]  btarget_i,
   input  logic             tf_class_i,
   input  logic [1:0]       tf_kind_i,
   input  logic [XLEN-1:0]  tf_addr_i,
   input  logic [XLEN-1:0]  esr_cur_i,
   input  logic [XLEN-1:0]  ear_cur_i,
   input  logic [XLEN-1:0]  btr_cur_i,
   output logic [XLEN-1:0]  esr_nxt_o,
   output logic [XLEN-1:0]  ear_nxt_o,
   output logic [XLEN-1:0]  btr_nxt_o,
   output logic [RF_AW-1:0] lr_addr_o,
   output logic [XLEN-1:0]  lr_data_o,
   output logic [XLEN-1:0]  vec_o
);

   localparam logic [XLEN-1:0] STEP    = XLEN'(4);
   localparam logic [XLEN-1:0] VEC_IRQ = BASE_VEC + XLEN'(VOFS_IRQ);
   localparam logic [XLEN-1:0] VEC_BRK = BASE_VEC + XLEN'(VOFS_BRK);
   localparam logic [XLEN-1:0] VEC_EXC = BASE_VEC + XLEN'(VOFS_EXC);

   logic [XLEN-1:0]      rewind;
   logic [XLEN-1:0]      tf_esr;
   logic [SY_CODE_W-1:0] tf_code;
   logic                 is_fetch;
   logic                 is_store;

   assign is_fetch = (tf_kind_i == TF_FETCH);
   assign is_store = (tf_kind_i == TF_STORE);
   assign tf_code  = SY_CODE_W'(SY_TF_BASE) + {3'b000, tf_class_i, 1'b0} + {4'b0000, is_fetch};

   always_comb begin
      tf_esr           = '0;
      tf_esr[SY_CODE_W-1:0] = tf_code;
      tf_esr[SY_STORE] = is_store;
      tf_esr[SY_DSLOT] = in_dslot_i;
   end

   // re-execute distance for a translation fault
   always_comb begin
      if (in_dslot_i)       rewind = branch_imm_i ? (STEP + STEP) : STEP;
      else if (after_imm_i) rewind = STEP;
      else                  rewind = '0;
   end

   always_comb begin
      esr_nxt_o = esr_cur_i;
      ear_nxt_o = ear_cur_i;
      btr_nxt_o = btr_cur_i;
      lr_addr_o = '0;
      lr_data_o = '0;
      vec_o     = '0;
      unique case (kind_i)
         TK_IRQ: begin
            lr_addr_o = RF_AW'(LR_IRQ);
            lr_data_o = pc_i;
            vec_o     = VEC_IRQ;
         end
         TK_BRK: begin
            lr_addr_o = RF_AW'(LR_BRK);
            lr_data_o = pc_i;
            vec_o     = VEC_BRK;
         end
         TK_HWEXC: begin
            lr_addr_o = RF_AW'(LR_EXC);
            lr_data_o = pc_i + STEP;
            vec_o     = VEC_EXC;
            esr_nxt_o[SY_DSLOT] = in_dslot_i;
            if (in_dslot_i) btr_nxt_o = btarget_i;
         end
         TK_TFAULT: begin
            lr_addr_o = RF_AW'(LR_EXC);
            lr_data_o = pc_i - rewind;
            vec_o     = VEC_EXC;
            esr_nxt_o = tf_esr;
            ear_nxt_o = tf_addr_i;
            if (in_dslot_i) btr_nxt_o = btarget_i;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_entry_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              RF_AW    = 5,
   parameter logic [XLEN-1:0] BASE_VEC = '0,
   parameter bit              EXC_EN   = 1'b1,
   parameter int              LR_IRQ   = 14,
   parameter int              LR_BRK   = 16,
   parameter int              LR_EXC   = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [XLEN-1:0]  pc_i,
   input  logic             in_dslot_i,
   input  logic             after_imm_i,
   input  logic             branch_imm_i,
   input  logic [XLEN-1:0]  btarget_i,
   input  logic             irq_i,
   input  logic             brk_req_i,
   input  logic             hwexc_req_i,
   input  logic             tfault_req_i,
   input  logic             tf_class_i,
   input  logic [1:0]       tf_kind_i,
   input  logic [XLEN-1:0]  tf_addr_i,
   input  logic             msr_we_i,
   input  logic [XLEN-1:0]  msr_wdata_i,
   output logic             rf_we_o,
   output logic [RF_AW-1:0] rf_waddr_o,
   output logic [XLEN-1:0]  rf_wdata_o,
   output logic             pc_load_o,
   output logic [XLEN-1:0]  pc_next_o,
   output logic             flag_clr_o,
   output logic [XLEN-1:0]  msr_o,
   output logic [XLEN-1:0]  esr_o,
   output logic [XLEN-1:0]  ear_o,
   output logic [XLEN-1:0]  btr_o,
   output logic             recursive_err_o
);

   localparam int RF_DEPTH = 1 << RF_AW;

   generate
      if (XLEN <= ST_TOP || XLEN < 16) begin : g_bad_xlen
         initial $error("trap_entry_ctrl: XLEN too small for status layout");
      end
      if (LR_IRQ >= RF_DEPTH || LR_BRK >= RF_DEPTH || LR_EXC >= RF_DEPTH) begin : g_bad_lr
         initial $error("trap_entry_ctrl: link register index out of range");
      end
      if (BASE_VEC[4:0] != 5'd0) begin : g_bad_base
         initial $error("trap_entry_ctrl: vector base must be 32-byte aligned");
      end
   endgenerate

   trap_kind_e      kind;
   logic            recur;
   logic [XLEN-1:0] msr_q, esr_q, ear_q, btr_q;
   logic [XLEN-1:0] msr_nxt, esr_nxt, ear_nxt, btr_nxt;
   logic [RF_AW-1:0] lr_addr;
   logic [XLEN-1:0] lr_data, vec;
   logic            tf_busy_q, err_q;
   logic            taking;

   trap_arbiter #(.EXC_EN(EXC_EN)) u_arb (
      .irq_i       (irq_i),
      .brk_i       (brk_req_i),
      .hwexc_i     (hwexc_req_i),
      .tfault_i    (tfault_req_i),
      .ie_i        (msr_q[ST_IE]),
      .eip_i       (msr_q[ST_EIP]),
      .bip_i       (msr_q[ST_BIP]),
      .in_dslot_i  (in_dslot_i),
      .after_imm_i (after_imm_i),
      .tf_busy_i   (tf_busy_q),
      .kind_o      (kind),
      .recur_o     (recur)
   );

   trap_msr_upd #(.XLEN(XLEN)) u_msr (
      .msr_cur_i   (msr_q),
      .kind_i      (kind),
      .msr_we_i    (msr_we_i),
      .msr_wdata_i (msr_wdata_i),
      .msr_nxt_o   (msr_nxt)
   );

   trap_syndrome #(
      .XLEN(XLEN), .RF_AW(RF_AW), .BASE_VEC(BASE_VEC),
      .LR_IRQ(LR_IRQ), .LR_BRK(LR_BRK), .LR_EXC(LR_EXC)
   ) u_syn (
      .kind_i       (kind),
      .pc_i         (pc_i),
      .in_dslot_i   (in_dslot_i),
      .after_imm_i  (after_imm_i),
      .branch_imm_i (branch_imm_i),
      .btarget_i    (btarget_i),
      .tf_class_i   (tf_class_i),
      .tf_kind_i    (tf_kind_i),
      .tf_addr_i    (tf_addr_i),
      .esr_cur_i    (esr_q),
      .ear_cur_i    (ear_q),
      .btr_cur_i    (btr_q),
      .esr_nxt_o    (esr_nxt),
      .ear_nxt_o    (ear_nxt),
      .btr_nxt_o    (btr_nxt),
      .lr_addr_o    (lr_addr),
      .lr_data_o    (lr_data),
      .vec_o        (vec)
   );

   assign taking = (kind != TK_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msr_q      <= '0;
         esr_q      <= '0;
         ear_q      <= '0;
         btr_q      <= '0;
         tf_busy_q  <= 1'b0;
         err_q      <= 1'b0;
         rf_we_o    <= 1'b0;
         rf_waddr_o <= '0;
         rf_wdata_o <= '0;
         pc_load_o  <= 1'b0;
         pc_next_o  <= '0;
         flag_clr_o <= 1'b0;
      end else begin
         msr_q      <= msr_nxt;
         esr_q      <= esr_nxt;
         ear_q      <= ear_nxt;
         btr_q      <= btr_nxt;
         err_q      <= err_q | recur;
         rf_we_o    <= taking;
         rf_waddr_o <= lr_addr;
         rf_wdata_o <= lr_data;
         pc_load_o  <= taking;
         pc_next_o  <= vec;
         flag_clr_o <= taking;
         if (kind == TK_TFAULT)
            tf_busy_q <= 1'b1;
         else if (!taking && msr_we_i && !msr_wdata_i[ST_EIP])
            tf_busy_q <= 1'b0;
      end
   end

   assign msr_o           = msr_q;
   assign esr_o           = esr_q;
   assign ear_o           = ear_q;
   assign btr_o           = btr_q;
   assign recursive_err_o = err_q;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
   import trap_entry_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              RF_AW    = 5,
   parameter logic [XLEN-1:0] BASE_VEC = '0,
   parameter int              LR_IRQ   = 14,
   parameter int              LR_BRK   = 16,
   parameter int              LR_EXC   = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic [XLEN-1:0]  pc_i,
   input logic             in_dslot_i,
   input logic             after_imm_i,
   input logic             irq_i,
   input logic             brk_req_i,
   input logic             hwexc_req_i,
   input logic             tfault_req_i,
   input logic             rf_we_o,
   input logic [RF_AW-1:0] rf_waddr_o,
   input logic [XLEN-1:0]  rf_wdata_o,
   input logic             pc_load_o,
   input logic [XLEN-1:0]  pc_next_o,
   input logic [XLEN-1:0]  msr_o,
   input logic             recursive_err_o
);

   // R1: no interrupt entry inside a delay slot or after a prefix
   p_irq_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i && !brk_req_i && !hwexc_req_i && !tfault_req_i && (in_dslot_i || after_imm_i))
      |=> !pc_load_o);

   // R2: interrupt vector, link value and cleared enable
   p_irq_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && rf_we_o && rf_waddr_o == RF_AW'(LR_IRQ))
      |-> (pc_next_o == BASE_VEC + XLEN'(VOFS_IRQ) && !msr_o[ST_IE] && rf_wdata_o == $past(pc_i)));

   // R2: no back-to-back interrupt entry
   p_irq_no_reentry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && rf_waddr_o == RF_AW'(LR_IRQ)) |=> !(pc_load_o && rf_waddr_o == RF_AW'(LR_IRQ)));

   // R3: a break request always enters the break vector next cycle
   p_brk_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req_i |=> (pc_load_o && rf_waddr_o == RF_AW'(LR_BRK) && msr_o[ST_BIP]
                     && pc_next_o == BASE_VEC + XLEN'(VOFS_BRK)));

   // R4: exception vector and in-progress flag
   p_exc_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && rf_waddr_o == RF_AW'(LR_EXC))
      |-> (pc_next_o == BASE_VEC + XLEN'(VOFS_EXC) && msr_o[ST_EIP]));

   // R5: mode bits moved up and cleared on every entry
   p_mode_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> (!msr_o[ST_VM] && !msr_o[ST_UM]
                     && msr_o[ST_VMS] == $past(msr_o[ST_VM])
                     && msr_o[ST_UMS] == $past(msr_o[ST_UM])));

   // R10: recursive fault error is sticky
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      recursive_err_o |=> recursive_err_o);

endmodule

bind trap_entry_ctrl trap_entry_chk #(
   .XLEN(XLEN), .RF_AW(RF_AW), .BASE_VEC(BASE_VEC),
   .LR_IRQ(LR_IRQ), .LR_BRK(LR_BRK), .LR_EXC(LR_EXC)
) u_chk (.*);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;

   localparam logic [31:0] BASE = 32'h0000_4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [31:0] pc, btarget, tf_addr, msr_wdata;
   logic in_dslot, after_imm, branch_imm, irq, brk, hwexc, tfault, tf_class, msr_we;
   logic [1:0] tf_kind;

   logic        rf_we, pc_load, flag_clr, rerr;
   logic [4:0]  rf_waddr;
   logic [31:0] rf_wdata, pc_next, msr, esr, ear, btr;

   logic        n_rf_we, n_pc_load, n_flag_clr, n_rerr;
   logic [4:0]  n_rf_waddr;
   logic [31:0] n_rf_wdata, n_pc_next, n_msr, n_esr, n_ear, n_btr;

   trap_entry_ctrl #(.BASE_VEC(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .pc_i(pc), .in_dslot_i(in_dslot), .after_imm_i(after_imm),
      .branch_imm_i(branch_imm), .btarget_i(btarget), .irq_i(irq), .brk_req_i(brk),
      .hwexc_req_i(hwexc), .tfault_req_i(tfault), .tf_class_i(tf_class), .tf_kind_i(tf_kind),
      .tf_addr_i(tf_addr), .msr_we_i(msr_we), .msr_wdata_i(msr_wdata),
      .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .pc_load_o(pc_load),
      .pc_next_o(pc_next), .flag_clr_o(flag_clr), .msr_o(msr), .esr_o(esr), .ear_o(ear),
      .btr_o(btr), .recursive_err_o(rerr));

   trap_entry_ctrl #(.BASE_VEC(BASE), .EXC_EN(1'b0)) u_dut_noexc (
      .clk(clk), .rst_n(rst_n), .pc_i(pc), .in_dslot_i(in_dslot), .after_imm_i(after_imm),
      .branch_imm_i(branch_imm), .btarget_i(btarget), .irq_i(irq), .brk_req_i(brk),
      .hwexc_req_i(hwexc), .tfault_req_i(tfault), .tf_class_i(tf_class), .tf_kind_i(tf_kind),
      .tf_addr_i(tf_addr), .msr_we_i(msr_we), .msr_wdata_i(msr_wdata),
      .rf_we_o(n_rf_we), .rf_waddr_o(n_rf_waddr), .rf_wdata_o(n_rf_wdata), .pc_load_o(n_pc_load),
      .pc_next_o(n_pc_next), .flag_clr_o(n_flag_clr), .msr_o(n_msr), .esr_o(n_esr), .ear_o(n_ear),
      .btr_o(n_btr), .recursive_err_o(n_rerr));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] m_msr, m_esr, m_ear, m_btr;
   logic        m_busy, m_err;
   logic        e_we;
   logic [4:0]  e_waddr;
   logic [31:0] e_wdata, e_pc;
   string       e_tag;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mode_save(input logic [31:0] s);
      logic [31:0] r;
      r = s;
      r[14] = s[13]; r[12] = s[11]; r[13] = 1'b0; r[11] = 1'b0;
      return r;
   endfunction

   task automatic model_step();
      logic irq_ok, tf_ok;
      irq_ok = irq && m_msr[1] && !m_msr[9] && !m_msr[3] && !in_dslot && !after_imm;
      tf_ok  = tfault && !m_busy;
      if (tfault && m_busy) m_err = 1'b1;
      e_we = 1'b1;
      if (brk) begin
         e_tag = "R3"; e_waddr = 5'd16; e_wdata = pc; e_pc = BASE + 32'h18;
         m_msr = mode_save(m_msr); m_msr[3] = 1'b1;
      end else if (tf_ok) begin
         e_tag = "R8"; e_waddr = 5'd17; e_pc = BASE + 32'h20;
         if (in_dslot)       e_wdata = pc - (branch_imm ? 32'd8 : 32'd4);
         else if (after_imm) e_wdata = pc - 32'd4;
         else                e_wdata = pc;
         m_msr = mode_save(m_msr); m_msr[9] = 1'b1;
         m_esr = 32'd16 + {30'd0, tf_class, 1'b0} + {31'd0, tf_kind == 2'b10};
         m_esr[10] = (tf_kind == 2'b01);
         m_esr[12] = in_dslot;
         m_ear = tf_addr;
         if (in_dslot) m_btr = btarget;
         m_busy = 1'b1;
      end else if (hwexc) begin
         e_tag = "R4"; e_waddr = 5'd17; e_wdata = pc + 32'd4; e_pc = BASE + 32'h20;
         m_msr = mode_save(m_msr); m_msr[9] = 1'b1;
         m_esr[12] = in_dslot;
         if (in_dslot) m_btr = btarget;
      end else if (irq_ok) begin
         e_tag = "R2"; e_waddr = 5'd14; e_wdata = pc; e_pc = BASE + 32'h10;
         m_msr = mode_save(m_msr); m_msr[1] = 1'b0;
      end else begin
         e_tag = irq ? "R1" : "R12"; e_we = 1'b0; e_waddr = 5'd0; e_wdata = 32'd0; e_pc = 32'd0;
         if (msr_we) begin
            m_msr = msr_wdata;
            if (!msr_wdata[9]) m_busy = 1'b0;
         end
      end
   endtask

   task automatic idle_inputs();
      irq = 0; brk = 0; hwexc = 0; tfault = 0; msr_we = 0; in_dslot = 0; after_imm = 0;
      branch_imm = 0; tf_class = 0; tf_kind = 2'b00; msr_wdata = 0;
   endtask

   // inputs are set at a falling edge before calling; checks at the next falling edge
   task automatic step_check();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(e_tag, "rf_we", {31'd0, rf_we}, {31'd0, e_we});
      chk("R11", "pc_load", {31'd0, pc_load}, {31'd0, e_we});
      chk("R11", "flag_clr", {31'd0, flag_clr}, {31'd0, e_we});
      if (e_we) begin
         chk(e_tag, "rf_waddr", {27'd0, rf_waddr}, {27'd0, e_waddr});
         chk(e_tag, "rf_wdata", rf_wdata, e_wdata);
         chk(e_tag, "pc_next", pc_next, e_pc);
      end
      chk("R5", "msr", msr, m_msr);
      chk("R7", "esr", esr, m_esr);
      chk("R7", "ear", ear, m_ear);
      chk("R6", "btr", btr, m_btr);
      chk("R10", "recursive_err", {31'd0, rerr}, {31'd0, m_err});
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      idle_inputs();
      pc = 32'h100; btarget = 32'h0; tf_addr = 32'h0;
      m_msr = 0; m_esr = 0; m_ear = 0; m_btr = 0; m_busy = 0; m_err = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      chk("R12", "reset msr", msr, 32'd0);
      chk("R12", "reset pc_load", {31'd0, pc_load}, 32'd0);
      chk("R12", "reset err", {31'd0, rerr}, 32'd0);

      // R9: exception ignored when exception support is off
      hwexc = 1; pc = 32'h200; in_dslot = 1; btarget = 32'h7700;
      step_check();
      chk("R9", "noexc rf_we", {31'd0, n_rf_we}, 32'd0);
      chk("R9", "noexc pc_load", {31'd0, n_pc_load}, 32'd0);
      chk("R9", "noexc msr", n_msr, 32'd0);
      chk("R9", "noexc btr", n_btr, 32'd0);

      // R12 status load, enable interrupts with VM/UM set
      idle_inputs(); msr_we = 1; msr_wdata = 32'h0000_2802;
      step_check();
      // R1: interrupt in a delay slot is held off
      idle_inputs(); irq = 1; in_dslot = 1;
      step_check();
      idle_inputs(); irq = 1; after_imm = 1;
      step_check();
      // R2 interrupt taken
      idle_inputs(); irq = 1; pc = 32'h340;
      step_check();
      // R11 priority: all four at once -> break
      idle_inputs(); msr_we = 1; msr_wdata = 32'h0000_2002;
      step_check();
      idle_inputs(); irq = 1; brk = 1; hwexc = 1; tfault = 1; pc = 32'h500;
      step_check();
      // R8 fault re-execute variants, clearing the in-service mark between them
      for (int v = 0; v < 4; v++) begin
         idle_inputs(); msr_we = 1; msr_wdata = 32'h0000_2800;
         step_check();
         idle_inputs(); tfault = 1; pc = 32'h800 + 32'(v * 16); tf_addr = 32'hABC0 + 32'(v);
         in_dslot = (v == 1 || v == 2); branch_imm = (v == 2); after_imm = (v == 3);
         tf_class = v[0]; tf_kind = 2'(v % 3); btarget = 32'h9000 + 32'(v);
         step_check();
      end
      // R10 recursive fault
      idle_inputs(); tfault = 1; tf_kind = 2'b10;
      step_check();
      chk("R10", "recursive flag", {31'd0, rerr}, 32'd1);
      idle_inputs(); msr_we = 1; msr_wdata = 32'h0;
      step_check();
      chk("R10", "sticky flag", {31'd0, rerr}, 32'd1);

      // constrained random
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         idle_inputs();
         r = $urandom();
         brk = (r[3:0] == 4'd0);
         tfault = (r[6:4] == 3'd0);
         hwexc = (r[9:7] == 3'd0);
         irq = r[10];
         msr_we = (r[12:11] == 2'd0);
         in_dslot = (r[14:13] == 2'd0);
         after_imm = !in_dslot && (r[17:15] == 3'd0);
         branch_imm = r[18];
         tf_class = r[19];
         tf_kind = (r[21:20] == 2'd3) ? 2'd0 : r[21:20];
         r = $urandom();
         msr_wdata = r & 32'h0000_7A0A;
         msr_wdata[1] = (r[31:30] != 2'd0);
         msr_wdata[9] = (r[29:27] == 3'd0);
         msr_wdata[3] = (r[26:24] == 3'd0);
         r = $urandom(); pc = r & 32'hFFFF_FFFC;
         r = $urandom(); btarget = r & 32'hFFFF_FFFC;
         tf_addr = $urandom();
         step_check();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule